// File: doc/BRIEF.md
# Bandwidth-Throttled Request Admission Unit

This unit sits in front of a simple memory responder and decides, cycle by cycle, whether the request offered on a valid/ready handshake is taken or turned away. Each request carries a command code, a size in bytes, read and write flags, a flag that says a response is wanted, and an inhibit flag. Inhibit means another agent will answer. An accepted read or write makes the unit busy for `size * cycles_per_byte` cycles. This models a short-term bandwidth ceiling. While the unit is busy it refuses ordinary requests, and it promises the refused requester one retry pulse when the busy period ends.

Accepted requests that are not inhibited appear one cycle later on a forward strobe toward the backing RAM. The strobe carries the command, size and write flag. A second strobe pushes the request into the response queue when a response is wanted. An inhibited request is always taken and then discarded. It causes no memory access, no response and no change of state.

Three named states drive the control. In IDLE, requests are accepted. In BUSY, the timer runs and nobody is owed a retry. In OWED, the timer runs and one retry is owed. The named transitions are: START (IDLE to BUSY on an accepted read or write with nonzero duration), REFUSE (BUSY to OWED when an ordinary request is refused), FREE (BUSY to IDLE on expiry, with a retry pulse if a refusal lands in that same final cycle), and RETRY (OWED to IDLE on expiry, with a retry pulse).

Top module: `bw_admit`

## Requirements
- R1: A valid request with `req_inhibit`=1 sees `req_ready`=1 in any state. It produces no `mem_req` and no `rsp_push` in the following cycle, and it leaves the busy timing and retry status untouched.
- R2: In IDLE, a valid request that is not inhibited is accepted (`req_ready`=1). In the next cycle `mem_req`=1, with `mem_cmd`, `mem_size` and `mem_wr` equal to the accepted request's fields.
- R3: `rsp_push` is 1 in the cycle after an accepted, non-inhibited request exactly when that request had `req_needs_rsp`=1.
- R4: An accepted read or write holds `req_ready` low (for non-inhibited offers) for exactly `req_size * cfg_cyc_per_byte` cycles, counted from the cycle after acceptance.
- R5: When `req_size * cfg_cyc_per_byte` is zero, the unit never leaves IDLE, and `req_ready` stays 1 in the next cycle.
- R6: A command with neither the read flag nor the write flag set never starts a busy period, whatever its size.
- R7: A non-inhibited request offered while busy is refused (`req_ready`=0) and is not forwarded. The unit then owes one retry.
- R8: While a retry is owed, further refused requests change nothing, and the busy period ends with exactly one retry pulse.
- R9: When a busy period with a retry owed expires, `retry_pulse` is 1 for exactly one cycle: the first cycle after the last busy cycle. `req_ready` is 1 in that cycle.
- R10: A request refused in the final busy cycle still earns a retry pulse in the next cycle.
- R11: A busy period that expires with no retry owed produces no retry pulse.
- R12: Reset (`rst_n`=0) clears the busy state, the owed retry and the timer. After reset, `req_ready`=1 and `retry_pulse`, `mem_req` and `rsp_push` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cyc_per_byte | input | CPB_W | Busy cycles charged per byte |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_cmd | input | CMD_W | Command code |
| req_size | input | SIZE_W | Request size in bytes |
| req_rd | input | 1 | Request is a read |
| req_wr | input | 1 | Request is a write |
| req_needs_rsp | input | 1 | Request expects a response |
| req_inhibit | input | 1 | Another agent answers; consume silently |
| retry_pulse | output | 1 | One-cycle retry notice to a refused requester |
| mem_req | output | 1 | Forward strobe to backing RAM |
| mem_cmd | output | CMD_W | Forwarded command |
| mem_size | output | SIZE_W | Forwarded size |
| mem_wr | output | 1 | Forwarded write flag |
| rsp_push | output | 1 | Push into the response queue |

## Verification
The bench builds the unit with its defaults: 8-bit size and cycles-per-byte fields, a 16-bit timer and a 4-bit command. Every product of size and cycles-per-byte therefore fits the timer without saturation, and the exact busy length can be measured cycle by cycle at `req_ready`. Because the cycles-per-byte factor is a run-time input, one build covers zero factors, zero sizes, one-cycle periods and periods of a dozen cycles or more. With those short periods, refusals early in a period, in its last cycle and while a retry is already owed can all be placed on exact cycles.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_OWED = 2'd2
    } adm_state_e;
endpackage

// File: rtl/bwa_duration.sv
module bwa_duration #(
    parameter int SIZE_W = 8,
    parameter int CPB_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [CPB_W-1:0]  cpb_i,
    output logic [CNT_W-1:0]  dur_o,
    output logic              zero_o
);
    localparam int PROD_W = SIZE_W + CPB_W;

    logic [PROD_W-1:0] prod;
    assign prod = PROD_W'(size_i) * PROD_W'(cpb_i);

    generate
        if (PROD_W > CNT_W) begin : g_sat
            // clamp products the timer cannot hold
            assign dur_o = (|prod[PROD_W-1:CNT_W]) ? {CNT_W{1'b1}} : prod[CNT_W-1:0];
        end else begin : g_ext
            assign dur_o = CNT_W'(prod);
        end
    endgenerate

    assign zero_o = (prod == '0);
endmodule

// File: rtl/bwa_timer.sv
module bwa_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = (cnt_q == ONE);
endmodule

// File: rtl/bwa_fsm.sv
module bwa_fsm
    import bwa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic       req_inhibit_i,
    input  logic       req_rd_i,
    input  logic       req_wr_i,
    input  logic       req_needs_rsp_i,
    input  logic       dur_zero_i,
    input  logic       expire_i,
    output logic       req_ready_o,
    output logic       load_o,
    output logic       fwd_o,
    output logic       rsp_o,
    output logic       retry_o,
    output adm_state_e state_o
);
    adm_state_e st_q, st_d;
    logic       retry_d, retry_q;
    logic       plain_req;
    logic       refuse;

    assign plain_req = req_valid_i && !req_inhibit_i;
    assign refuse    = plain_req && (st_q != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            retry_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            retry_q <= retry_d;
        end
    end

    // transitions
    always_comb begin
        st_d    = st_q;
        retry_d = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (plain_req && (req_rd_i || req_wr_i) && !dur_zero_i) begin
                    st_d = ST_BUSY;          // START
                end
            end
            ST_BUSY: begin
                if (expire_i) begin
                    st_d    = ST_IDLE;       // FREE
                    retry_d = refuse;
                end else if (refuse) begin
                    st_d = ST_OWED;          // REFUSE
                end
            end
            ST_OWED: begin
                if (expire_i) begin
                    st_d    = ST_IDLE;       // RETRY
                    retry_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready_o = req_inhibit_i;
        load_o      = 1'b0;
        fwd_o       = 1'b0;
        rsp_o       = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready_o = 1'b1;
                fwd_o       = plain_req;
                rsp_o       = plain_req && req_needs_rsp_i;
                load_o      = plain_req && (req_rd_i || req_wr_i) && !dur_zero_i;
            end
            ST_BUSY, ST_OWED: begin
                req_ready_o = req_inhibit_i;
            end
            default: req_ready_o = req_inhibit_i;
        endcase
    end

    assign retry_o = retry_q;
    assign state_o = st_q;
endmodule

// File: rtl/bw_admit.sv
module bw_admit
    import bwa_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int CPB_W  = 8,
    parameter int CNT_W  = 16,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPB_W-1:0]  cfg_cyc_per_byte,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_needs_rsp,
    input  logic              req_inhibit,
    output logic              retry_pulse,
    output logic              mem_req,
    output logic [CMD_W-1:0]  mem_cmd,
    output logic [SIZE_W-1:0] mem_size,
    output logic              mem_wr,
    output logic              rsp_push
);
    logic [CNT_W-1:0] dur;
    logic             dur_zero;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             load;
    logic             fwd;
    logic             rsp;
    adm_state_e       st_q;

    bwa_duration #(.SIZE_W(SIZE_W), .CPB_W(CPB_W), .CNT_W(CNT_W)) u_dur (
        .size_i (req_size),
        .cpb_i  (cfg_cyc_per_byte),
        .dur_o  (dur),
        .zero_o (dur_zero)
    );

    bwa_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (dur),
        .cnt_o      (cnt_q),
        .expire_o   (expire)
    );

    bwa_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_inhibit_i   (req_inhibit),
        .req_rd_i        (req_rd),
        .req_wr_i        (req_wr),
        .req_needs_rsp_i (req_needs_rsp),
        .dur_zero_i      (dur_zero),
        .expire_i        (expire),
        .req_ready_o     (req_ready),
        .load_o          (load),
        .fwd_o           (fwd),
        .rsp_o           (rsp),
        .retry_o         (retry_pulse),
        .state_o         (st_q)
    );

    // forward stage toward RAM and response queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_cmd  <= '0;
            mem_size <= '0;
            mem_wr   <= 1'b0;
            rsp_push <= 1'b0;
        end else begin
            mem_req  <= fwd;
            rsp_push <= rsp;
            if (fwd) begin
                mem_cmd  <= req_cmd;
                mem_size <= req_size;
                mem_wr   <= req_wr;
            end
        end
    end
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
    import bwa_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_inhibit,
    input logic             retry_pulse,
    input logic             mem_req,
    input logic             rsp_push,
    input logic             dur_zero,
    input adm_state_e       st_q,
    input logic [CNT_W-1:0] cnt_q
);
    p_inh_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inhibit) |-> req_ready);

    p_inh_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inhibit) |=> (!mem_req && !rsp_push));

    p_rsp_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push |-> mem_req);

    p_timer_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) == (cnt_q != '0));

    p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && req_valid && !req_inhibit && dur_zero) |=> (st_q == ST_IDLE));

    p_refuse_nofwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !mem_req);

    p_retry_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |=> !retry_pulse);

    p_retry_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> (st_q == ST_IDLE));

    p_nobusy_noretry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && cnt_q == CNT_W'(1) && !(req_valid && !req_inhibit)) |=> !retry_pulse);
endmodule

bind bw_admit bwa_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_inhibit (req_inhibit),
    .retry_pulse (retry_pulse),
    .mem_req     (mem_req),
    .rsp_push    (rsp_push),
    .dur_zero    (dur_zero),
    .st_q        (st_q),
    .cnt_q       (cnt_q)
);

// File: tb/sim_bw_admit.sv
`timescale 1ns/1ps
module sim_bw_admit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpb = '0;
    logic       valid = 1'b0, ready;
    logic [3:0] cmd = '0;
    logic [7:0] size = '0;
    logic       rd = 1'b0, wr = 1'b0, nrsp = 1'b0, inh = 1'b0;
    logic       retry, mreq, mwr, rpush;
    logic [3:0] mcmd;
    logic [7:0] msize;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bw_admit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cyc_per_byte(cpb),
        .req_valid(valid), .req_ready(ready), .req_cmd(cmd), .req_size(size),
        .req_rd(rd), .req_wr(wr), .req_needs_rsp(nrsp), .req_inhibit(inh),
        .retry_pulse(retry), .mem_req(mreq), .mem_cmd(mcmd), .mem_size(msize),
        .mem_wr(mwr), .rsp_push(rpush)
    );

    typedef struct packed {
        logic       inh;
        logic       rd;
        logic       wr;
        logic       rsp;
        logic [3:0] cmd;
        logic [7:0] size;
        logic [7:0] cpb;
        logic       e_mem;
        logic       e_rsp;
        logic [15:0] e_busy;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,4'h1,8'd4, 8'd3,1'b1,1'b1,16'd12},
        '{1'b0,1'b0,1'b1,1'b0,4'h2,8'd16,8'd1,1'b1,1'b0,16'd16},
        '{1'b1,1'b1,1'b0,1'b1,4'h3,8'd8, 8'd2,1'b0,1'b0,16'd0},
        '{1'b0,1'b0,1'b0,1'b1,4'h7,8'd10,8'd5,1'b1,1'b1,16'd0},
        '{1'b0,1'b1,1'b0,1'b1,4'h4,8'd0, 8'd7,1'b1,1'b1,16'd0},
        '{1'b0,1'b0,1'b1,1'b1,4'h5,8'd5, 8'd0,1'b1,1'b1,16'd0},
        '{1'b0,1'b1,1'b0,1'b0,4'h6,8'd1, 8'd1,1'b1,1'b0,16'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        valid = 1'b0; inh = 1'b0; rd = 1'b0; wr = 1'b0; nrsp = 1'b0;
    endtask

    // count cycles with ready low for a plain observer (valid=0, inhibit=0)
    task automatic busy_len(output int n);
        n = 0;
        while (!ready && n < 70000) begin
            n++;
            tick();
        end
    endtask

    task automatic offer(input logic i, input logic r, input logic w, input logic p,
                         input logic [3:0] c, input logic [7:0] s);
        valid = 1'b1; inh = i; rd = r; wr = w; nrsp = p; cmd = c; size = s;
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int cyc;
        int pulses;
        repeat (3) tick();
        // R12 reset state
        chk(ready === 1'b1, "R12 ready after reset", ready, 1);
        chk(retry === 1'b0 && mreq === 1'b0 && rpush === 1'b0, "R12 outputs quiet", {retry,mreq,rpush}, 0);
        rst_n = 1'b1;
        tick();

        // table walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            cpb = VEC[k].cpb;
            offer(VEC[k].inh, VEC[k].rd, VEC[k].wr, VEC[k].rsp, VEC[k].cmd, VEC[k].size);
            #0.5;
            chk(ready === 1'b1, "R2/R1 accept from idle", ready, 1);
            tick();
            idle_in();
            #0.5;
            chk(mreq === VEC[k].e_mem, "R2/R1 mem_req", mreq, VEC[k].e_mem);
            chk(rpush === VEC[k].e_rsp, "R3 rsp_push", rpush, VEC[k].e_rsp);
            if (VEC[k].e_mem)
                chk(mcmd === VEC[k].cmd && msize === VEC[k].size && mwr === VEC[k].wr,
                    "R2 forwarded fields", msize, VEC[k].size);
            busy_len(n);
            chk(n == int'(VEC[k].e_busy), "R4/R5/R6 busy length", n, VEC[k].e_busy);
            tick();
        end

        // R7 R8 R9: refusal while busy, repeated refusal while owed, single retry
        cpb = 8'd2;
        offer(1'b0, 1'b1, 1'b0, 1'b1, 4'h1, 8'd4);   // duration 8
        tick();
        offer(1'b0, 1'b0, 1'b1, 1'b1, 4'h2, 8'd3);
        #0.5;
        chk(ready === 1'b0, "R7 refused while busy", ready, 0);
        tick();
        #0.5;
        chk(mreq === 1'b0, "R7 refused not forwarded", mreq, 0);
        offer(1'b0, 1'b1, 1'b0, 1'b0, 4'h3, 8'd9);
        #0.5;
        chk(ready === 1'b0, "R8 refused while owed", ready, 0);
        tick();
        // R1: inhibited offer in busy is taken silently, timing unchanged
        offer(1'b1, 1'b1, 1'b0, 1'b1, 4'h4, 8'd200);
        #0.5;
        chk(ready === 1'b1, "R1 inhibit accepted while busy", ready, 1);
        tick();
        idle_in();
        #0.5;
        chk(mreq === 1'b0 && rpush === 1'b0, "R1 inhibit silent", {mreq,rpush}, 0);
        // now 3 cycles after acceptance; retry expected after 8
        cyc = 3; pulses = 0;
        while (!retry && cyc < 40) begin tick(); cyc++; end
        chk(cyc == 8, "R9 retry timing", cyc, 8);
        chk(ready === 1'b1, "R9 ready with retry", ready, 1);
        for (int j = 0; j < 10; j++) begin
            if (retry) pulses++;
            tick();
        end
        chk(pulses == 1, "R8/R9 exactly one retry", pulses, 1);

        // R10: refusal in the final busy cycle
        cpb = 8'd1;
        offer(1'b0, 1'b0, 1'b1, 1'b0, 4'h5, 8'd3);   // duration 3
        tick();
        idle_in();
        tick(); tick();                              // last busy cycle now
        offer(1'b0, 1'b1, 1'b0, 1'b0, 4'h6, 8'd1);
        #0.5;
        chk(ready === 1'b0, "R10 still busy in last cycle", ready, 0);
        tick();
        idle_in();
        #0.5;
        chk(retry === 1'b1, "R10 retry after last-cycle refusal", retry, 1);
        tick();
        chk(retry === 1'b0, "R9 retry one cycle wide", retry, 0);

        // R11: expiry with nothing owed
        offer(1'b0, 1'b1, 1'b0, 1'b0, 4'h7, 8'd2);   // duration 2
        tick();
        idle_in();
        pulses = 0;
        for (int j = 0; j < 6; j++) begin
            if (retry) pulses++;
            tick();
        end
        chk(pulses == 0, "R11 no retry without refusal", pulses, 0);

        // R12: reset during a busy period with a retry owed
        cpb = 8'd10;
        offer(1'b0, 1'b1, 1'b0, 1'b0, 4'h1, 8'd10);
        tick();
        offer(1'b0, 1'b1, 1'b0, 1'b0, 4'h1, 8'd1);
        tick();
        idle_in();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #0.5;
        chk(ready === 1'b1, "R12 reset clears busy", ready, 1);
        pulses = 0;
        for (int j = 0; j < 120; j++) begin
            if (retry) pulses++;
            tick();
        end
        chk(pulses == 0, "R12 reset drops owed retry", pulses, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule